// File: doc/BRIEF.md
# Quad Screen-Space Derivative Unit

This block produces the horizontal and vertical rate of change of one shader register across a 2x2 pixel quad whose four pipes run in lock-step. Each cycle it may accept the four per-pixel values of the chosen register. It forms one horizontal derivative and one vertical derivative for the whole quad, and it hands the same pair to all four pipes one clock later.

When the register is a temporary, each derivative is the difference between neighbouring pixels of the quad. The result means something only when every pipe of the quad has reached the same point in the program. If the quad has diverged, the unit raises an invalid flag and drives zero in place of the derivatives. When the register is an interpolated input, the caller already has the per-pixel delta. A bypass then forwards that delta unchanged, and the state of convergence plays no part.

Values are signed fixed-point numbers `W` bits wide. A difference that does not fit in `W` bits is clamped to the nearest limit of the signed range.

Top module: `quad_deriv_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `out_invalid`, every lane of `out_ddx` and every lane of `out_ddy` are zero.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high, giving a fixed latency of one clock.
- R3: In temporary mode (`in_src` = 0) with `in_converged` high, the horizontal result is pixel 1 minus pixel 0. Pixel p occupies bits [p*W +: W] of `in_pix`: 0 is top-left, 1 is top-right, 2 is bottom-left and 3 is bottom-right.
- R4: In temporary mode with `in_converged` high, the vertical result is pixel 2 minus pixel 0.
- R5: A difference above 2^(W-1)-1 is returned as 2^(W-1)-1, and a difference below -2^(W-1) is returned as -2^(W-1).
- R6: Pixel 3 (bottom-right) has no effect on any output.
- R7: All four W-bit lanes of `out_ddx` carry the same value, and all four lanes of `out_ddy` carry the same value.
- R8: In bypass mode (`in_src` = 1), the results are `in_interp_dx` and `in_interp_dy` unchanged and `out_invalid` is low, whatever the values of `in_pix` and `in_converged`.
- R9: In temporary mode with `in_converged` low, `out_invalid` is high and both results are zero.
- R10: A cycle with `in_valid` low leaves `out_ddx`, `out_ddy` and `out_invalid` at the values they held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Quad operand present this cycle |
| in_src | input | 1 | 0 = temporary (neighbour difference), 1 = interpolator bypass |
| in_converged | input | 1 | All four pipes of the quad are in lock-step |
| in_pix | input | 4*W | Register value of pixels 0..3, pixel p at bits [p*W +: W] |
| in_interp_dx | input | W | Horizontal delta supplied by the interpolator |
| in_interp_dy | input | W | Vertical delta supplied by the interpolator |
| out_valid | output | 1 | Result present, one cycle after in_valid |
| out_invalid | output | 1 | Result undefined because the quad had diverged |
| out_ddx | output | 4*W | Horizontal derivative, broadcast to lanes 0..3 |
| out_ddy | output | 4*W | Vertical derivative, broadcast to lanes 0..3 |

## Verification
Directed quads cover a flat register, which must give zero, and a pure horizontal ramp and a pure vertical ramp. The two ramps show whether the horizontal and vertical neighbours are the right pixels and whether they are subtracted in the right order. Extreme pixel pairs push each difference past both signed limits, which separates a clamped result from a wrapped one. A run of random quads then changes only the bottom-right value, so any output that moves exposes a tap on pixel 3. Random operands mix the three source conditions: bypass with a divergent quad, temporary with a converged quad, and temporary with a divergent quad. Idle cycles carry garbage operands and show whether the held result stays put.

// File: rtl/quad_deriv_pkg.sv
package quad_deriv_pkg;

  // Source of the operand whose rate of change is requested
  typedef enum logic {
    SRC_NEIGHBOUR = 1'b0,
    SRC_INTERP    = 1'b1
  } deriv_src_e;

  // Pixel order inside the packed quad operand
  localparam int QUAD_PIXELS = 4;
  localparam int PIX_TL      = 0;
  localparam int PIX_TR      = 1;
  localparam int PIX_BL      = 2;
  localparam int PIX_BR      = 3;

  // Lanes that receive the broadcast result
  localparam int QUAD_LANES  = 4;

endpackage

// File: rtl/qd_sat_sub.sv
module qd_sat_sub #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] minuend,
  input  logic signed [W-1:0] subtrahend,
  output logic signed [W-1:0] diff,
  output logic                clipped
);

  localparam int WX = W + 1;
  localparam logic signed [WX-1:0] POS_LIM = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [WX-1:0] NEG_LIM = {2'b11, {(W-1){1'b0}}};

  // Exact difference in one extra bit
  function automatic logic signed [WX-1:0] wide_diff(
    input logic signed [W-1:0] a,
    input logic signed [W-1:0] b
  );
    logic signed [WX-1:0] ax;
    logic signed [WX-1:0] bx;
    ax = {a[W-1], a};
    bx = {b[W-1], b};
    return ax - bx;
  endfunction

  // Clamp a wide value to the W-bit signed range
  function automatic logic signed [W-1:0] clamp_to_w(input logic signed [WX-1:0] v);
    if (v > POS_LIM)      return POS_LIM[W-1:0];
    else if (v < NEG_LIM) return NEG_LIM[W-1:0];
    else                  return v[W-1:0];
  endfunction

  logic signed [WX-1:0] exact;

  always_comb begin
    exact   = wide_diff(minuend, subtrahend);
    diff    = clamp_to_w(exact);
    clipped = (exact > POS_LIM) || (exact < NEG_LIM);
  end

  // R5: the clamped result never takes the sign opposite to the true difference
  always_comb begin
    if (minuend >= subtrahend)
      p_sat_sign_pos_r5: assert (diff >= 0);
    if (minuend < subtrahend)
      p_sat_sign_neg_r5: assert (diff < 0);
  end

endmodule

// File: rtl/qd_pick.sv
module qd_pick
  import quad_deriv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] pix_tl,
  input  logic signed [W-1:0] pix_tr,
  input  logic signed [W-1:0] pix_bl,
  input  logic signed [W-1:0] interp_dx,
  input  logic signed [W-1:0] interp_dy,
  input  deriv_src_e          src,
  input  logic                converged,
  output logic signed [W-1:0] dx,
  output logic signed [W-1:0] dy,
  output logic                undefined
);

  logic signed [W-1:0] nb_dx;
  logic signed [W-1:0] nb_dy;
  logic                dx_clip;
  logic                dy_clip;

  // Horizontal neighbour: right minus left along the top row
  qd_sat_sub #(.W(W)) u_sub_x (
    .minuend    (pix_tr),
    .subtrahend (pix_tl),
    .diff       (nb_dx),
    .clipped    (dx_clip)
  );

  // Vertical neighbour: lower minus upper along the left column
  qd_sat_sub #(.W(W)) u_sub_y (
    .minuend    (pix_bl),
    .subtrahend (pix_tl),
    .diff       (nb_dy),
    .clipped    (dy_clip)
  );

  // Named events for the checks
  logic use_interp;
  logic diverged_temp;
  assign use_interp    = (src == SRC_INTERP);
  assign diverged_temp = !use_interp && !converged;

  always_comb begin
    dx        = '0;
    dy        = '0;
    undefined = 1'b0;
    if (use_interp) begin
      dx = interp_dx;
      dy = interp_dy;
    end else if (!converged) begin
      undefined = 1'b1;
    end else begin
      dx = nb_dx;
      dy = nb_dy;
    end
  end

  // R9: a diverged temporary yields zero and the undefined mark
  always_comb begin
    if (diverged_temp)
      p_diverged_zero_r9: assert (undefined && dx == '0 && dy == '0);
  end

  // R8: the bypass never reports an undefined result
  always_comb begin
    if (use_interp)
      p_bypass_defined_r8: assert (!undefined);
  end

  // R5: a clipped lane sits at one of the two range limits
  always_comb begin
    if (!use_interp && converged && dx_clip)
      p_clip_at_limit_r5: assert (nb_dx == {1'b0, {(W-1){1'b1}}} || nb_dx == {1'b1, {(W-1){1'b0}}});
  end

endmodule

// File: rtl/qd_out_stage.sv
module qd_out_stage #(
  parameter int W     = 16,
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic signed [W-1:0]   dx,
  input  logic signed [W-1:0]   dy,
  input  logic                  undefined,
  output logic                  valid_q,
  output logic                  undefined_q,
  output logic [LANES*W-1:0]    dx_lanes,
  output logic [LANES*W-1:0]    dy_lanes
);

  logic signed [W-1:0] dx_q;
  logic signed [W-1:0] dy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q     <= 1'b0;
      undefined_q <= 1'b0;
      dx_q        <= '0;
      dy_q        <= '0;
    end else begin
      valid_q <= load;
      if (load) begin
        undefined_q <= undefined;
        dx_q        <= dx;
        dy_q        <= dy;
      end
    end
  end

  // One shared result fanned out to every pipe of the quad
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dx_lanes[g*W +: W] = dx_q;
    assign dy_lanes[g*W +: W] = dy_q;
  end

  // R2: result appears exactly one clock after the operand
  p_latency_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid_q);
  p_latency_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !valid_q);

  // R10: idle cycles leave the stored result untouched
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(dx_q) && $stable(dy_q) && $stable(undefined_q)));

endmodule

// File: rtl/quad_deriv_unit.sv
module quad_deriv_unit
  import quad_deriv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_src,
  input  logic                        in_converged,
  input  logic [QUAD_PIXELS*W-1:0]    in_pix,
  input  logic [W-1:0]                in_interp_dx,
  input  logic [W-1:0]                in_interp_dy,
  output logic                        out_valid,
  output logic                        out_invalid,
  output logic [QUAD_LANES*W-1:0]     out_ddx,
  output logic [QUAD_LANES*W-1:0]     out_ddy
);

  logic signed [W-1:0] pix_tl;
  logic signed [W-1:0] pix_tr;
  logic signed [W-1:0] pix_bl;
  deriv_src_e          src_sel;

  // Bottom-right pixel is not tapped by either derivative
  assign pix_tl  = in_pix[PIX_TL*W +: W];
  assign pix_tr  = in_pix[PIX_TR*W +: W];
  assign pix_bl  = in_pix[PIX_BL*W +: W];
  assign src_sel = deriv_src_e'(in_src);

  logic signed [W-1:0] pick_dx;
  logic signed [W-1:0] pick_dy;
  logic                pick_undef;

  qd_pick #(.W(W)) u_pick (
    .pix_tl    (pix_tl),
    .pix_tr    (pix_tr),
    .pix_bl    (pix_bl),
    .interp_dx (in_interp_dx),
    .interp_dy (in_interp_dy),
    .src       (src_sel),
    .converged (in_converged),
    .dx        (pick_dx),
    .dy        (pick_dy),
    .undefined (pick_undef)
  );

  qd_out_stage #(.W(W), .LANES(QUAD_LANES)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (in_valid),
    .dx          (pick_dx),
    .dy          (pick_dy),
    .undefined   (pick_undef),
    .valid_q     (out_valid),
    .undefined_q (out_invalid),
    .dx_lanes    (out_ddx),
    .dy_lanes    (out_ddy)
  );

  // Named event: an accepted operand that asks for the interpolator bypass
  logic take_bypass;
  logic take_diverged;
  assign take_bypass   = in_valid && in_src;
  assign take_diverged = in_valid && !in_src && !in_converged;

  // R8: bypass forwards the supplied deltas on the next clock
  p_bypass_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_bypass |=> (!out_invalid &&
                     out_ddx[W-1:0] == $past(in_interp_dx) &&
                     out_ddy[W-1:0] == $past(in_interp_dy)));

  // R9: a diverged temporary comes out flagged and zeroed
  p_invalid_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_diverged |=> (out_invalid && out_ddx == '0 && out_ddy == '0));

  // R7: the top and bottom lanes always agree
  p_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ddx[W-1:0] == out_ddx[(QUAD_LANES-1)*W +: W] &&
                   out_ddy[W-1:0] == out_ddy[(QUAD_LANES-1)*W +: W]));

endmodule

// File: tb/quad_deriv_unit_tb.sv
module quad_deriv_unit_tb_top;

  localparam int W = 16;
  localparam int LIM_POS = (1 << (W-1)) - 1;
  localparam int LIM_NEG = -(1 << (W-1));

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic             in_src;
  logic             in_converged;
  logic [4*W-1:0]   in_pix;
  logic [W-1:0]     in_interp_dx;
  logic [W-1:0]     in_interp_dy;
  logic             out_valid;
  logic             out_invalid;
  logic [4*W-1:0]   out_ddx;
  logic [4*W-1:0]   out_ddy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Model of the last accepted result
  int  exp_dx  = 0;
  int  exp_dy  = 0;
  bit  exp_inv = 0;

  quad_deriv_unit #(.W(W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_src       (in_src),
    .in_converged (in_converged),
    .in_pix       (in_pix),
    .in_interp_dx (in_interp_dx),
    .in_interp_dy (in_interp_dy),
    .out_valid    (out_valid),
    .out_invalid  (out_invalid),
    .out_ddx      (out_ddx),
    .out_ddy      (out_ddy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int clip(int v);
    if (v > LIM_POS) return LIM_POS;
    if (v < LIM_NEG) return LIM_NEG;
    return v;
  endfunction

  function automatic int sx(logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Check every lane against the model
  task automatic check_outputs(string req, bit valid_exp);
    check(out_valid == valid_exp, "R2", int'(out_valid), int'(valid_exp));
    check(out_invalid == exp_inv, req, int'(out_invalid), int'(exp_inv));
    for (int l = 0; l < 4; l++) begin
      check(sx(out_ddx[l*W +: W]) == exp_dx, {req, " R7 ddx"}, sx(out_ddx[l*W +: W]), exp_dx);
      check(sx(out_ddy[l*W +: W]) == exp_dy, {req, " R7 ddy"}, sx(out_ddy[l*W +: W]), exp_dy);
    end
  endtask

  // Drive one operand at a falling edge, check one cycle later
  task automatic issue(bit src, bit conv, int tl, int tr, int bl, int br,
                       int idx, int idy, string req);
    in_valid     = 1'b1;
    in_src       = src;
    in_converged = conv;
    in_pix       = {br[W-1:0], bl[W-1:0], tr[W-1:0], tl[W-1:0]};
    in_interp_dx = idx[W-1:0];
    in_interp_dy = idy[W-1:0];
    if (src) begin
      exp_dx = sx(idx[W-1:0]); exp_dy = sx(idy[W-1:0]); exp_inv = 0;
    end else if (!conv) begin
      exp_dx = 0; exp_dy = 0; exp_inv = 1;
    end else begin
      exp_dx = clip(sx(tr[W-1:0]) - sx(tl[W-1:0]));
      exp_dy = clip(sx(bl[W-1:0]) - sx(tl[W-1:0]));
      exp_inv = 0;
    end
    @(negedge clk);
    check_outputs(req, 1'b1);
  endtask

  // Idle cycle with garbage on the operand pins
  task automatic idle_cycle();
    in_valid     = 1'b0;
    in_src       = 1'($urandom);
    in_converged = 1'($urandom);
    in_pix       = {$urandom, $urandom};
    in_interp_dx = W'($urandom);
    in_interp_dy = W'($urandom);
    @(negedge clk);
    check_outputs("R10", 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0;
    in_valid = 1'b0; in_src = 1'b0; in_converged = 1'b1;
    in_pix = '0; in_interp_dx = '0; in_interp_dy = '0;
    repeat (3) @(negedge clk);
    check_outputs("R1", 1'b0);
    in_valid = 1'b1;
    in_pix = {16'd9, 16'd7, 16'd5, 16'd1};
    @(negedge clk);
    check_outputs("R1", 1'b0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check_outputs("R1", 1'b0);

    // Directed: flat, horizontal ramp, vertical ramp
    issue(0, 1, 100, 100, 100, 100, 0, 0, "R3 flat");
    issue(0, 1, 10, 35, 10, 35, 0, 0, "R3 hramp");
    issue(0, 1, -20, -20, 44, 44, 0, 0, "R4 vramp");
    issue(0, 1, 7, -3, 50, 9, 0, 0, "R3 R4 mixed");
    // Saturation at both ends
    issue(0, 1, LIM_NEG, LIM_POS, LIM_NEG, 0, 0, 0, "R5 pos");
    issue(0, 1, LIM_POS, LIM_NEG, -2, 0, 0, 0, "R5 neg");
    issue(0, 1, -1, LIM_POS, LIM_POS, 0, 0, 0, "R5 edge");
    // Bypass with divergence and garbage pixels
    issue(1, 0, 1234, -77, 5, 6, 321, -654, "R8 bypass");
    issue(1, 1, LIM_POS, LIM_NEG, 0, 0, LIM_NEG, LIM_POS, "R8 bypass ext");
    // Diverged temporary
    issue(0, 0, 1, 200, 300, 4, 11, 22, "R9 diverged");
    idle_cycle();
    idle_cycle();
    issue(0, 1, 3, 8, 13, 0, 0, 0, "R3 after idle");
    idle_cycle();

    // R6: only bottom-right moves
    for (int k = 0; k < 20; k++) begin
      int tl, tr, bl;
      tl = sx(W'($urandom)); tr = sx(W'($urandom)); bl = sx(W'($urandom));
      issue(0, 1, tl, tr, bl, sx(W'($urandom)), 0, 0, "R6 br first");
      issue(0, 1, tl, tr, bl, sx(W'($urandom)), 0, 0, "R6 br changed");
    end

    // Random mix
    for (int k = 0; k < 400; k++) begin
      if (($urandom % 5) == 0) idle_cycle();
      else issue(1'($urandom % 3 == 0), 1'($urandom % 4 != 0),
                 sx(W'($urandom)), sx(W'($urandom)), sx(W'($urandom)),
                 sx(W'($urandom)), sx(W'($urandom)), sx(W'($urandom)),
                 "R3 R4 R5 R8 R9 random");
    end

    idle_cycle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule